// File: doc/BRIEF.md
# Floppy Read-Track Byte Path

This block is the execution-phase data path of a floppy controller that is running a read-track command without DMA. A decoder upstream presents one decoded disk byte per byte-clock tick, nominally every 32 µs: a 500 kbit/s encoded stream gives 250 kbit/s once decoded. Each byte lands in a single holding register. There is no FIFO. The CPU polls a ready flag and takes the byte through a handshake. When a fresh byte arrives while the held one is still unread, the block latches an overrun. It replaces the byte and keeps streaming until the requested length is used up. The transfer therefore runs past the sector payload into the CRC and gap bytes, whose standard fill value is 0x4E.

When the transfer ends, the same output port delivers seven result bytes: three status bytes, then the cylinder, head, sector and size code latched from the command. The overrun shows in the second status byte. The disk side cannot be held back, so `disk_valid` has no ready. On the CPU side, `out_valid`/`out_ready` form a valid/ready pair. During execution the only form of back-pressure is a late read, and a late read costs bytes. During the result phase each byte waits for its read.

Top module: `fdc_rdtrack_path`

## Requirements
- R1: After reset `out_valid`, `busy`, `out_dir` and `res_phase` are 0.
- R2: A `cmd_start` pulse while idle begins execution. Each `disk_valid` cycle during execution loads `disk_data` into the register, and in the next cycle `out_valid` is 1 with that byte on `out_data`. `out_dir` equals `busy`.
- R3: A cycle with `out_valid` and `out_ready` both high consumes the byte, so `out_valid` is 0 in the next cycle unless a new byte loaded in that same cycle. A read and a load in the same cycle do not raise overrun.
- R4: A load while the held byte is unread and not being read sets a sticky overrun and replaces the byte. The stream keeps running to the full length, so a reader that takes one byte in three sees every third disk byte.
- R5: The execution length in bytes is 128 shifted left by the size code, clamped at MAX_SIZE. Size 3 gives 1024 bytes. Bytes past the payload, such as gap 0x4E, are delivered like any other byte.
- R6: Once all bytes are loaded, execution ends at the first cycle in which the held byte has been read or a further `disk_valid` arrives. A further `disk_valid` that finds the last byte unread also sets overrun. `res_phase` rises in the next cycle.
- R7: The result phase presents seven bytes in this order, each held with `out_valid` high until read: ST0, ST1, ST2, cylinder, head, sector, size. ST1 bit 4 is the overrun flag. ST0 bits 7:6 are 01 on overrun and 00 otherwise, and ST0 bit 2 is head bit 0. All other status bits are 0. After the seventh read the block is idle.
- R8: A read strobe while no byte is pending changes neither `out_data` nor the overrun flag.
- R9: `disk_valid` outside execution and `cmd_start` while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start pulse for a read-track command |
| cmd_cyl | input | 8 | Cylinder field echoed in the result |
| cmd_head | input | 8 | Head field echoed in the result |
| cmd_sector | input | 8 | Sector field echoed in the result |
| cmd_size | input | 8 | Size code; sets length 128 << code |
| disk_valid | input | 1 | Byte-clock tick carrying a decoded byte |
| disk_data | input | 8 | Decoded disk byte |
| out_valid | output | 1 | Byte ready for the CPU (request-for-master) |
| out_ready | input | 1 | CPU read strobe |
| out_data | output | 8 | Data register or result byte |
| out_dir | output | 1 | 1 = controller-to-CPU direction |
| busy | output | 1 | Command in progress |
| res_phase | output | 1 | Result phase active |

## Verification
The hardest situation to reach is the one where the stream keeps running under a steady overrun all the way to the end of execution. The last byte is then still unread when the closing tick arrives, and this has to set overrun without a load. The bench ticks the disk every fourth clock and pulses the read strobe once every twelve clocks. This creates repeated overruns and a closing tick that finds the last byte unread, and the bench checks that the bytes received are exactly every third disk index. A second run holds the read strobe high for the whole command. This produces reads with no byte pending and a read that coincides with a load, and neither may raise overrun.

// File: rtl/fdc_rt_pkg.sv
package fdc_rt_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_EXEC = 2'd1,
    PH_RES  = 2'd2
  } phase_t;

  localparam int RES_BYTES = 7;
  localparam int OVR_BIT   = 4;

  function automatic logic [7:0] st0_of(input logic ovr, input logic hd0);
    return {(ovr ? 2'b01 : 2'b00), 3'b000, hd0, 2'b00};
  endfunction

  function automatic logic [7:0] st1_of(input logic ovr);
    logic [7:0] v;
    v = 8'h00;
    v[OVR_BIT] = ovr;
    return v;
  endfunction
endpackage

// File: rtl/rt_byte_reg.sv
module rt_byte_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic         probe,
  input  logic         rd,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         pending,
  output logic         overrun
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout    <= '0;
      pending <= 1'b0;
      overrun <= 1'b0;
    end else if (clr) begin
      pending <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if ((load || probe) && pending && !rd) overrun <= 1'b1;
      if (load) begin
        dout    <= din;
        pending <= 1'b1;
      end else if (rd || probe) begin
        pending <= 1'b0;
      end
    end
  end

  assert_load_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> (pending && dout == $past(din)));
  assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !load && !clr) |=> !pending);
  assert_overrun_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !clr) |=> overrun);
  assert_idle_read_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !pending && !load && !probe && !clr) |=> ($stable(dout) && $stable(overrun)));
endmodule

// File: rtl/rt_xfer_ctrl.sv
module rt_xfer_ctrl
  import fdc_rt_pkg::*;
#(
  parameter int MAX_SIZE = 6,
  parameter int CW = $clog2((128 << MAX_SIZE) + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] size,
  input  logic       disk_valid,
  input  logic       pending,
  input  logic       res_done,
  output phase_t     phase,
  output logic       clr,
  output logic       load,
  output logic       finish
);
  logic [CW-1:0] total_q;
  logic [CW-1:0] cnt_q;
  logic [7:0]    size_c;

  assign size_c = (size > 8'(MAX_SIZE)) ? 8'(MAX_SIZE) : size;
  assign clr    = (phase == PH_IDLE) && start;
  assign load   = (phase == PH_EXEC) && disk_valid && (cnt_q < total_q);
  assign finish = (phase == PH_EXEC) && (cnt_q == total_q) && (!pending || disk_valid);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      total_q <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (start) begin
          phase   <= PH_EXEC;
          total_q <= CW'(128) << size_c;
          cnt_q   <= '0;
        end
        PH_EXEC: begin
          if (load) cnt_q <= cnt_q + 1'b1;
          if (finish) phase <= PH_RES;
        end
        PH_RES: if (res_done) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_EXEC) |-> (cnt_q <= total_q));
  assert_end_to_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (phase == PH_RES));
endmodule

// File: rtl/rt_result_seq.sv
module rt_result_seq
  import fdc_rt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       capture,
  input  logic       enter,
  input  logic       advance,
  input  logic       overrun,
  input  logic [7:0] cyl,
  input  logic [7:0] head,
  input  logic [7:0] sector,
  input  logic [7:0] size,
  output logic [7:0] rbyte,
  output logic       last
);
  localparam int IW = $clog2(RES_BYTES);
  logic [IW-1:0] idx_q;
  logic [7:0]    c_q, h_q, r_q, n_q;

  assign last = (idx_q == IW'(RES_BYTES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      c_q <= '0; h_q <= '0; r_q <= '0; n_q <= '0;
    end else begin
      if (capture) begin
        c_q <= cyl; h_q <= head; r_q <= sector; n_q <= size;
      end
      if (enter) idx_q <= '0;
      else if (advance && !last) idx_q <= idx_q + 1'b1;
    end
  end

  always_comb begin
    unique case (idx_q)
      IW'(0): rbyte = st0_of(overrun, h_q[0]);
      IW'(1): rbyte = st1_of(overrun);
      IW'(2): rbyte = 8'h00;
      IW'(3): rbyte = c_q;
      IW'(4): rbyte = h_q;
      IW'(5): rbyte = r_q;
      IW'(6): rbyte = n_q;
      default: rbyte = 8'h00;
    endcase
  end

  assert_index_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IW'(RES_BYTES - 1));
endmodule

// File: rtl/fdc_rdtrack_path.sv
module fdc_rdtrack_path
  import fdc_rt_pkg::*;
#(
  parameter int MAX_SIZE = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_start,
  input  logic [7:0] cmd_cyl,
  input  logic [7:0] cmd_head,
  input  logic [7:0] cmd_sector,
  input  logic [7:0] cmd_size,
  input  logic       disk_valid,
  input  logic [7:0] disk_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_dir,
  output logic       busy,
  output logic       res_phase
);
  phase_t     phase;
  logic       clr, load, finish, pending, overrun, res_last, res_rd;
  logic [7:0] reg_byte, res_byte;

  assign res_rd = (phase == PH_RES) && out_ready;

  rt_xfer_ctrl #(.MAX_SIZE(MAX_SIZE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(cmd_start), .size(cmd_size),
    .disk_valid(disk_valid), .pending(pending), .res_done(res_rd && res_last),
    .phase(phase), .clr(clr), .load(load), .finish(finish)
  );

  rt_byte_reg #(.W(8)) u_reg (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load(load), .probe(finish),
    .rd((phase == PH_EXEC) && out_ready), .din(disk_data),
    .dout(reg_byte), .pending(pending), .overrun(overrun)
  );

  rt_result_seq u_res (
    .clk(clk), .rst_n(rst_n), .capture(clr), .enter(finish), .advance(res_rd),
    .overrun(overrun), .cyl(cmd_cyl), .head(cmd_head), .sector(cmd_sector),
    .size(cmd_size), .rbyte(res_byte), .last(res_last)
  );

  assign busy      = (phase != PH_IDLE);
  assign out_dir   = busy;
  assign res_phase = (phase == PH_RES);
  assign out_valid = (phase == PH_EXEC) ? pending : (phase == PH_RES);
  assign out_data  = (phase == PH_RES) ? res_byte : reg_byte;

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmd_start) |=> (!busy && !out_valid));
  assert_result_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_phase && !out_ready) |=> (res_phase && $stable(out_data)));
endmodule

// File: tb/fdc_rdtrack_path_test.sv
module fdc_rdtrack_path_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_start = 1'b0;
  logic [7:0] cmd_cyl = 8'h00, cmd_head = 8'h00, cmd_sector = 8'h00, cmd_size = 8'h00;
  logic       disk_valid = 1'b0;
  logic [7:0] disk_data = 8'h00;
  logic       out_valid, out_ready, out_dir, busy, res_phase;
  logic [7:0] out_data;

  int compared = 0, mismatched = 0;
  int cyc = 0;
  int rmode = 0;
  int didx = 0;

  always #2.5 clk = ~clk;

  fdc_rdtrack_path uut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_cyl(cmd_cyl),
    .cmd_head(cmd_head), .cmd_sector(cmd_sector), .cmd_size(cmd_size),
    .disk_valid(disk_valid), .disk_data(disk_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_dir(out_dir),
    .busy(busy), .res_phase(res_phase)
  );
  initial out_ready = 1'b0;

  // behavioural reference
  int m_st = 0;              // 0 idle, 1 exec, 2 result
  int m_cnt, m_total, m_idx, m_regidx;
  bit m_pend, m_ovr;
  int m_reg;
  int m_c, m_h, m_r, m_n;
  int rx_data[$], rx_idx[$], rs_data[$];

  function automatic int gen(int i, int total);
    if (i < total / 2) return (i * 29 + 7) & 255;
    if (i < total / 2 + 2) return 8'hA5;
    return 8'h4E;
  endfunction

  function automatic int m_res(int k);
    case (k)
      0: return (m_ovr ? 8'h40 : 8'h00) | ((m_h & 1) << 2);
      1: return m_ovr ? 8'h10 : 8'h00;
      2: return 0;
      3: return m_c;
      4: return m_h;
      5: return m_r;
      default: return m_n;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_pend = 0; m_ovr = 0; m_reg = 0; m_cnt = 0; m_idx = 0;
      m_total = 0; m_regidx = 0;
    end else begin
      case (m_st)
        0: if (cmd_start) begin
          m_st = 1; m_cnt = 0; m_pend = 0; m_ovr = 0;
          m_total = 128 << ((cmd_size > 6) ? 6 : int'(cmd_size));
          m_c = cmd_cyl; m_h = cmd_head; m_r = cmd_sector; m_n = cmd_size;
          didx = 0;
        end
        1: begin
          if (m_cnt < m_total && disk_valid) begin
            if (m_pend && !out_ready) m_ovr = 1;
            m_reg = disk_data; m_pend = 1; m_regidx = m_cnt; m_cnt++;
          end else if (m_cnt == m_total && (!m_pend || disk_valid)) begin
            if (disk_valid && m_pend && !out_ready) m_ovr = 1;
            m_st = 2; m_idx = 0; m_pend = 0;
          end else if (out_ready) m_pend = 0;
        end
        default: if (out_ready) begin
          if (m_idx == 6) m_st = 0; else m_idx++;
        end
      endcase
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle compare, then reader and disk drive
  always @(negedge clk) begin
    if (rst_n) begin
      bit ev, eb;
      int ed;
      ev = (m_st == 1) ? m_pend : (m_st == 2);
      eb = (m_st != 0);
      ed = (m_st == 2) ? m_res(m_idx) : m_reg;
      check(out_valid == ev, "R3 out_valid", out_valid, ev);
      check(busy == eb && out_dir == eb, "R2 busy/dir", {busy, out_dir}, {eb, eb});
      check(res_phase == (m_st == 2), "R6 res_phase", res_phase, m_st == 2);
      if (ev) check(out_data == ed[7:0], "R2 out_data", out_data, ed);
    end
    cyc++;
    disk_valid <= 1'b0;
    if (rst_n && cyc % 4 == 0) begin
      disk_valid <= 1'b1;
      disk_data  <= 8'(gen(didx, (m_total == 0) ? 256 : m_total));
      didx++;
    end
    begin
      bit r;
      if (rmode == 2) r = 1'b1;
      else if (rmode == 1 && m_st == 1) r = out_valid && (cyc % 12 == 2);
      else r = out_valid;
      out_ready <= r;
      if (r && out_valid) begin
        if (m_st == 1) begin rx_data.push_back(out_data); rx_idx.push_back(m_regidx); end
        else if (m_st == 2) rs_data.push_back(out_data);
      end
    end
  end

  task automatic run_cmd(input int size, input int mode, input int c, input int h);
    rx_data.delete(); rx_idx.delete(); rs_data.delete();
    rmode = mode;
    @(negedge clk);
    cmd_start <= 1'b1; cmd_cyl <= 8'(c); cmd_head <= 8'(h);
    cmd_sector <= 8'hC1; cmd_size <= 8'(size);
    @(negedge clk);
    cmd_start <= 1'b0;
    repeat (40) @(negedge clk);
    // R9: second start while busy
    cmd_start <= 1'b1; cmd_cyl <= 8'h77;
    @(negedge clk);
    cmd_start <= 1'b0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #200000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!out_valid && !busy && !out_dir && !res_phase, "R1 reset state",
          {out_valid, busy, out_dir, res_phase}, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check(!out_valid && !busy, "R9 idle disk ticks ignored", {out_valid, busy}, 0);

    // prompt reader, size 1
    run_cmd(1, 0, 8'h12, 8'h01);
    check(rx_data.size() == 256, "R2 prompt count", rx_data.size(), 256);
    begin
      int bad = 0;
      foreach (rx_data[i]) if (rx_data[i] != gen(i, 256)) bad++;
      check(bad == 0, "R2 prompt sequence", bad, 0);
    end
    check(rs_data.size() == 7, "R7 result count", rs_data.size(), 7);
    if (rs_data.size() == 7) begin
      check(rs_data[0] == 8'h04, "R7 ST0 clean", rs_data[0], 8'h04);
      check(rs_data[1] == 8'h00, "R7 ST1 clean", rs_data[1], 0);
      check(rs_data[3] == 8'h12 && rs_data[6] == 1, "R9 fields kept", rs_data[3], 8'h12);
    end

    // slow reader, size 1
    run_cmd(1, 1, 8'h05, 8'h00);
    begin
      int bad = 0;
      for (int i = 1; i < rx_idx.size(); i++) if (rx_idx[i] - rx_idx[i-1] != 3) bad++;
      foreach (rx_data[i]) if (rx_data[i] != gen(rx_idx[i], 256)) bad++;
      check(bad == 0 && rx_idx.size() > 80, "R4 every third byte", bad, 0);
      check(rx_idx.size() > 0 && rx_idx[rx_idx.size()-1] >= 252, "R4 stream to end",
            rx_idx.size() > 0 ? rx_idx[rx_idx.size()-1] : -1, 253);
    end
    if (rs_data.size() == 7) begin
      check(rs_data[1] == 8'h10, "R4 ST1 overrun bit", rs_data[1], 8'h10);
      check(rs_data[0] == 8'h40, "R7 ST0 overrun code", rs_data[0], 8'h40);
    end else check(0, "R7 slow result count", rs_data.size(), 7);

    // reader always strobing, size 3
    run_cmd(3, 2, 8'h27, 8'h00);
    check(rx_data.size() == 1024, "R5 1024 bytes", rx_data.size(), 1024);
    if (rx_data.size() == 1024) begin
      check(rx_data[513] == 8'hA5, "R5 crc slot", rx_data[513], 8'hA5);
      check(rx_data[700] == 8'h4E, "R5 gap byte", rx_data[700], 8'h4E);
    end
    if (rs_data.size() == 7)
      check(rs_data[1] == 8'h00, "R8 idle reads no overrun", rs_data[1], 0);
    else check(0, "R8 result count", rs_data.size(), 7);

    repeat (10) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule